// File: doc/BRIEF.md
# Sliding-Window Pulse Rate Counter

This block reports how many rising edges arrived on a digital input during a trailing window of time that moves forward every tick. It does not use a fixed gate period. Each accepted edge records the current value of a free-running tick counter into a queue held in inferred block RAM. A head pointer marks where the next stamp is written. A tail pointer marks the oldest stamp still inside the window. The number of stamps between the two pointers is the reported count.

The raw input is asynchronous. It passes through a two-stage synchronizer, and a one-cycle strobe is formed on each rising edge. The tick counter advances once every `TICK_DIV` clock cycles and wraps freely. The age of a stamp is the modular difference between the current tick and that stamp. The oldest stamp is read from RAM with one cycle of latency. Once it is older than the window setting, it is retired. At most one stamp leaves the queue per cycle. If an edge arrives while the queue is full, that edge is discarded and a sticky flag is raised. Turning the count into a flow rate is left to a consumer downstream.

Top module: `pulse_window_counter`

## Requirements
- R1: After reset, `win_count` is 0 and `overflow` is 0.
- R2: Each low-to-high transition on `pulse_in` adds exactly one to `win_count`, once the input has been synchronized. An input held high for any number of cycles adds nothing further.
- R3: `win_count` equals the number of stored stamps. This is the head-to-tail distance modulo `DEPTH`, or `DEPTH` when the queue is full. It never exceeds `DEPTH`.
- R4: A stored stamp stays counted while (current tick − stamp) mod 2^`TS_W` ≤ `window_ticks`. The stamp is retired once that difference exceeds `window_ticks`, so pulses spread out in time leave the count one at a time.
- R5: At most one stamp is retired per clock cycle, so `win_count` never drops by more than 1 between consecutive cycles. A stamp is compared only after its one-cycle RAM read has completed for the current tail.
- R6: An edge that arrives while `DEPTH` stamps are stored is dropped, and `win_count` stays at `DEPTH`. `overflow` goes to 1 and stays 1 until reset, even after the queue drains.
- R7: Wraparound of the tick counter does not cause early or late expiry. `window_ticks` is limited to `TS_W`−1 bits, so it stays below half the tick range.
- R8: The tick counter advances by exactly one every `TICK_DIV` clock cycles. Window lengths are therefore measured in units of `TICK_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pulse_in | input | 1 | Raw, asynchronous pulse input |
| window_ticks | input | TS_W-1 | Window length in ticks |
| win_count | output | $clog2(DEPTH+1) | Number of pulses inside the window |
| overflow | output | 1 | Sticky flag: a pulse was dropped because the queue was full |

## Verification
The bench sweeps every window length of a small configuration with a six-entry queue and a six-bit timestamp. For each length it checks that the count holds until the window has elapsed and clears soon after. A wrong age comparison or a wrong tick rate would move that boundary. The sweeps run across many timestamp wraps. A subtraction that ignored wraparound would expire stamps early or keep them forever.

A burst sweep fills the queue to each depth from 1 to `DEPTH`. This includes a depth whose pointers wrap at a non-power-of-two boundary, which a pointer that wrapped only at a power of two would miscount.

An overflow test drives the queue past full. A design that wrote past the tail, or that cleared the flag when the queue drained, would show a wrong count or flag.

A per-cycle watch during the drain catches a design that retires stamps faster than one per cycle. Such a design would also act on stale RAM data during the read latency.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  // Modular increment for queue pointers whose depth need not be a power of two.
  function automatic int unsigned wrap_next(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/pwc_rst_sync.sv
module pwc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_sync = s2_q;
endmodule

// File: rtl/pwc_edge_sync.sv
module pwc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic meta_q, sync_q, prev_q;
  logic meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = din;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise = sync_q & ~prev_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R2
endmodule

// File: rtl/pwc_timebase.sv
module pwc_timebase #(
  parameter int TICK_DIV = 25000,
  parameter int TS_W     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] now_ts
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0]   div_q, div_d;
  logic [TS_W-1:0] ts_q, ts_d;
  logic            div_end;

  always_comb begin
    div_end = (div_q == PW'(TICK_DIV - 1));
    div_d   = div_end ? '0 : div_q + 1'b1;
    ts_d    = ts_q;
    if (div_end) ts_d = ts_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ts_q  <= '0;
    end else begin
      div_q <= div_d;
      if (div_end) ts_q <= ts_d;
    end
  end

  assign now_ts = ts_q;

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ts_q) |-> (ts_q == $past(ts_q) + 1'b1)); // R8
endmodule

// File: rtl/pwc_ts_ram.sv
module pwc_ts_ram #(
  parameter int DEPTH = 500,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // Synchronous read: old data returned on a same-address write.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pulse_window_counter.sv
module pulse_window_counter #(
  parameter int DEPTH    = 500,
  parameter int TS_W     = 16,
  parameter int TICK_DIV = 25000,
  localparam int AW      = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic [TS_W-2:0]  window_ticks,
  output logic [CNT_W-1:0] win_count,
  output logic             overflow
);
  import pwc_pkg::*;

  logic             rst_n_i;
  logic             rise;
  logic [TS_W-1:0]  now_ts;
  logic [TS_W-1:0]  rd_data;
  logic [TS_W-1:0]  age;

  logic [AW-1:0]    head_q, head_d, tail_q, tail_d, rd_tag_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d, clash_q, clash_d;
  logic             full, wr_en, rd_ok, expire;

  pwc_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_sync(rst_n_i));

  pwc_edge_sync u_edge (.clk(clk), .rst_n(rst_n_i), .din(pulse_in), .rise(rise));

  pwc_timebase #(.TICK_DIV(TICK_DIV), .TS_W(TS_W)) u_tb (
    .clk(clk), .rst_n(rst_n_i), .now_ts(now_ts)
  );

  pwc_ts_ram #(.DEPTH(DEPTH), .W(TS_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(head_q), .wdata(now_ts),
    .raddr(tail_q), .rdata(rd_data)
  );

  always_comb begin
    full    = (cnt_q == CNT_W'(DEPTH));
    wr_en   = rise & ~full;
    // Read data belongs to the current tail only if the tail did not move and
    // the slot was not being written during the read.
    rd_ok   = (cnt_q != '0) && (rd_tag_q == tail_q) && !clash_q;
    age     = now_ts - rd_data;
    expire  = rd_ok && (age > {1'b0, window_ticks});
    clash_d = wr_en && (head_q == tail_q);

    head_d = wr_en  ? AW'(wrap_next(32'(head_q), DEPTH)) : head_q;
    tail_d = expire ? AW'(wrap_next(32'(tail_q), DEPTH)) : tail_q;

    unique case ({wr_en, expire})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase

    ovf_d = ovf_q | (rise & full);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      head_q   <= '0;
      tail_q   <= '0;
      rd_tag_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
      clash_q  <= 1'b0;
    end else begin
      if (wr_en)  head_q <= head_d;
      if (expire) tail_q <= tail_d;
      if (wr_en || expire) cnt_q <= cnt_d;
      if (rise)   ovf_q  <= ovf_d;
      rd_tag_q <= tail_q;
      clash_q  <= clash_d;
    end
  end

  assign win_count = cnt_q;
  assign overflow  = ovf_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n_i)
    cnt_q <= CNT_W'(DEPTH)); // R3

  AST_PTR_DIST: assert property (@(posedge clk) disable iff (!rst_n_i)
    (int'(cnt_q) % DEPTH) ==
    ((int'(head_q) >= int'(tail_q)) ? int'(head_q) - int'(tail_q)
                                    : int'(head_q) + DEPTH - int'(tail_q))); // R3

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n_i)
    full |=> $stable(head_q)); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n_i)
    ovf_q |=> ovf_q); // R6

  AST_ONE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n_i)
    expire |=> !expire); // R5

  AST_RETIRE_DROP: assert property (@(posedge clk) disable iff (!rst_n_i)
    (expire && !wr_en) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
endmodule

// File: tb/pulse_window_counter_tb.sv
module pulse_window_counter_tb;
  localparam int DEPTH = 6;
  localparam int TS_W  = 6;
  localparam int DIV   = 4;
  localparam int CW    = $clog2(DEPTH + 1);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            pin;
  logic [TS_W-2:0] win;
  logic [CW-1:0]   cnt;
  logic            ovf;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pulse_window_counter #(.DEPTH(DEPTH), .TS_W(TS_W), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .pulse_in(pin), .window_ticks(win),
    .win_count(cnt), .overflow(ovf)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pin   = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic pulse();
    @(negedge clk);
    pin = 1'b1;
    wait_cyc(2);
    pin = 1'b0;
    wait_cyc(2);
  endtask

  // Long enough for any stored stamp to expire at the widest window and drain.
  task automatic drain();
    wait_cyc((32 + 2) * DIV + 2 * DEPTH + 8);
  endtask

  initial begin
    rst_n = 1'b0;
    pin   = 1'b0;
    win   = 5'd31;
    do_reset();
    chk("R1 count after reset", int'(cnt), 0);
    chk("R1 overflow after reset", int'(ovf), 0);

    // R2: a level held high counts once
    @(negedge clk);
    pin = 1'b1;
    wait_cyc(40);
    chk("R2 held level counts once", int'(cnt), 1);
    pin = 1'b0;
    drain();
    chk("R4 held pulse expired", int'(cnt), 0);

    // R2/R3: bursts of every depth up to full, pointers wrap at DEPTH
    for (int k = 1; k <= DEPTH; k++) begin
      for (int j = 0; j < k; j++) pulse();
      wait_cyc(2);
      chk($sformatf("R2 R3 burst of %0d", k), int'(cnt), k);
      chk("R6 no overflow below full", int'(ovf), 0);
      drain();
      chk($sformatf("R4 burst of %0d expired", k), int'(cnt), 0);
    end

    // R4/R7/R8: every window length, across many timestamp wraps
    for (int w = 1; w <= 31; w++) begin
      win = 5'(w);
      pulse();
      wait_cyc((w - 1) * DIV);
      chk($sformatf("R4 R8 held inside window %0d", w), int'(cnt), 1);
      wait_cyc(3 * DIV + 6);
      chk($sformatf("R4 R7 expired after window %0d", w), int'(cnt), 0);
    end

    // R7: start offsets spread over the tick wrap
    win = 5'd29;
    for (int o = 0; o < 16; o++) begin
      wait_cyc(o * 5 + 1);
      pulse();
      wait_cyc(28 * DIV);
      chk($sformatf("R7 offset %0d still counted", o), int'(cnt), 1);
      wait_cyc(3 * DIV + 6);
      chk($sformatf("R7 offset %0d expired", o), int'(cnt), 0);
    end

    // R4: staggered pulses leave one at a time
    win = 5'd20;
    pulse();
    wait_cyc(10 * DIV);
    pulse();
    wait_cyc(2);
    chk("R4 staggered both counted", int'(cnt), 2);
    wait_cyc(22 * DIV + 6 - 10 * DIV - 7);
    chk("R4 staggered first expired only", int'(cnt), 1);
    drain();
    chk("R4 staggered both expired", int'(cnt), 0);

    // R6: overfill
    win = 5'd31;
    for (int j = 0; j < DEPTH + 3; j++) pulse();
    wait_cyc(2);
    chk("R6 count saturates at depth", int'(cnt), DEPTH);
    chk("R6 overflow set", int'(ovf), 1);

    // R5: drain watched every cycle
    begin
      int prev = int'(cnt);
      int worst = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (prev - int'(cnt) > worst) worst = prev - int'(cnt);
        prev = int'(cnt);
      end
      chk("R5 largest single-cycle drop", worst, 1);
    end
    chk("R5 queue drained", int'(cnt), 0);
    chk("R6 overflow sticky after drain", int'(ovf), 1);

    do_reset();
    chk("R1 count after second reset", int'(cnt), 0);
    chk("R1 overflow cleared by reset", int'(ovf), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule